// File: doc/BRIEF.md
# Asynchronous-Strobe Writer for a USB Bridge Endpoint FIFO

This block moves 16-bit video words from an upstream ready/valid stream into an endpoint FIFO of a USB 2.0 bridge chip. The bridge runs in its external-master FIFO mode. Each word is committed on the rising (inactive-going) edge of an active-low write strobe. The strobe is timed by logic in this block, and no bridge clock is used. Before every word the block waits for the bridge's full flag to clear. That flag is first passed through a synchronizer.

A frame-start pulse arms the writer. From then on it accepts words until the upstream marks one as the last of the frame, and it writes each accepted word to the bridge. The bridge ships a packet by itself once a full endpoint packet has been written. If a frame ends partway through a packet, the block pulses the active-low packet-end line so that the bridge ships the remainder as a short packet. The block then needs a new frame-start pulse before it moves more data.

Top module: `usb_fifo_wr_master`

## Requirements
- R1: While the block is in reset and afterwards until a transfer starts, `cs_n`, `wr_n`, `oe_n` and `pktend_n` are high, `ep_addr` is 2'b00 and `s_ready` is low.
- R2: No word is accepted and no strobe is issued until a `vsync` pulse has armed the block. The last word of a frame disarms it, and words offered after that wait for the next `vsync`.
- R3: When a transfer starts, `ep_addr` takes the value `EP_CODE` (default 2'b10) and keeps it. `cs_n` is low from the address cycle through the end of the frame, covers every strobe, and returns high when the block is idle.
- R4: Each word gives one `wr_n` low pulse of exactly `WR_CYC` cycles. `fd` carries that word and holds it stable from the cycle `wr_n` falls until the cycle after it rises.
- R5: `oe_n` stays high at all times, so the bridge never drives the data bus.
- R6: A strobe never starts while the synchronized full flag is high. After `usb_full` falls, the next strobe begins on the third rising clock edge.
- R7: After each strobe, `wr_n` stays high for at least `SYNC_STAGES`+2 cycles (4 by default) before the next strobe. When upstream data is waiting and the bridge is not full, the gap is exactly that long.
- R8: Words reach `fd` in the order they were accepted, and each word is accepted on a cycle where both `s_valid` and `s_ready` are high. Pauses in upstream data cause no loss and no repeats.
- R9: If a frame's word count is not a multiple of `PKT_WORDS`, `pktend_n` goes low for exactly one cycle. That cycle starts one cycle after the last `wr_n` rise, and `cs_n` is still low during it.
- R10: If a frame's word count is a multiple of `PKT_WORDS`, `pktend_n` stays high for the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vsync | input | 1 | Frame-start pulse that arms the writer |
| s_valid | input | 1 | Upstream word valid |
| s_ready | output | 1 | Block takes the upstream word this cycle |
| s_data | input | 16 | Upstream data word |
| s_last | input | 1 | Marks the final word of a frame |
| usb_full | input | 1 | Bridge endpoint full flag, asynchronous, active high |
| ep_addr | output | 2 | Endpoint FIFO select |
| cs_n | output | 1 | Bridge FIFO chip select, active low |
| wr_n | output | 1 | Write strobe, active low; the word commits on its rise |
| oe_n | output | 1 | Bridge output enable, active low, held inactive |
| pktend_n | output | 1 | Short-packet commit, active low |
| fd | output | 16 | Data bus to the bridge |

## Verification
A word accepted at a rising edge puts `wr_n` low on that same edge. `wr_n` rises `WR_CYC` edges later. With data waiting, the next strobe falls four edges after that rise. `pktend_n` goes low one edge after the final rise and stays low for one cycle. After `usb_full` falls, a blocked strobe starts on the third edge. The bench drives inputs and samples every output on falling edges, so each value it reads has settled since the preceding rising edge. It measures these distances in whole cycles with a free-running cycle count and checks them against the numbers above.

// File: rtl/ufw_pkg.sv
package ufw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_CHECK  = 3'd2,
    ST_STROBE = 3'd3,
    ST_NEXT   = 3'd4,
    ST_COMMIT = 3'd5
  } wr_state_t;
endpackage

// File: rtl/ufw_flag_sync.sv
module ufw_flag_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ufw_pkt_count.sv
module ufw_pkt_count #(
  parameter int PKT_WORDS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_done,
  input  logic clear,
  output logic partial
);
  localparam int CW = (PKT_WORDS > 2) ? $clog2(PKT_WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PKT_WORDS - 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  always_comb begin
    cnt_en = word_done || clear;
    if (clear)              cnt_nx = '0;
    else if (cnt_q == LAST) cnt_nx = '0;
    else                    cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assign partial = (cnt_q != '0);

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/ufw_ctrl.sv
module ufw_ctrl
  import ufw_pkg::*;
#(
  parameter int               DATA_W      = 16,
  parameter int               ADDR_W      = 2,
  parameter logic [ADDR_W-1:0] EP_CODE    = 2'b10,
  parameter int               WR_CYC      = 2,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic              full_sync,
  input  logic              pkt_partial,
  output logic              word_done,
  output logic              pkt_clear,
  output logic [ADDR_W-1:0] ep_addr,
  output logic              cs_n,
  output logic              wr_n,
  output logic              oe_n,
  output logic              pktend_n,
  output logic [DATA_W-1:0] fd
);
  localparam int WCW = $clog2(WR_CYC + 1);
  localparam int SCW = $clog2(SYNC_STAGES + 1);
  localparam logic [WCW-1:0] W_END  = WCW'(WR_CYC - 1);
  localparam logic [SCW-1:0] SETTLE = SCW'(SYNC_STAGES);

  wr_state_t         state_q, state_nx;
  logic [WCW-1:0]    wcnt_q, wcnt_nx;
  logic [SCW-1:0]    settle_q, settle_nx;
  logic              armed_q, armed_nx;
  logic              last_q;
  logic [DATA_W-1:0] fd_q;
  logic [ADDR_W-1:0] ep_q;
  logic              cs_n_q, wr_n_q, pktend_n_q;
  logic              take, frame_end, ep_load;

  assign s_ready   = (state_q == ST_CHECK) && (settle_q == '0) && !full_sync;
  assign take      = s_ready && s_valid;
  assign word_done = (state_q == ST_STROBE) && (wcnt_q == W_END);
  assign pkt_clear = (state_q == ST_COMMIT);
  assign frame_end = pkt_clear || ((state_q == ST_NEXT) && last_q && !pkt_partial);
  assign ep_load   = (state_nx == ST_ADDR);

  always_comb begin
    state_nx  = state_q;
    wcnt_nx   = wcnt_q;
    settle_nx = settle_q;
    armed_nx  = vsync ? 1'b1 : (frame_end ? 1'b0 : armed_q);
    case (state_q)
      ST_IDLE:   if (armed_q && s_valid) state_nx = ST_ADDR;
      ST_ADDR: begin
        state_nx  = ST_CHECK;
        settle_nx = '0;
      end
      ST_CHECK: begin
        if (settle_q != '0) settle_nx = settle_q - 1'b1;
        else if (take) begin
          state_nx = ST_STROBE;
          wcnt_nx  = '0;
        end
      end
      ST_STROBE: begin
        if (wcnt_q == W_END) state_nx = ST_NEXT;
        else                 wcnt_nx  = wcnt_q + 1'b1;
      end
      ST_NEXT: begin
        if (last_q) state_nx = pkt_partial ? ST_COMMIT : ST_IDLE;
        else begin
          state_nx  = ST_CHECK;
          settle_nx = SETTLE;
        end
      end
      ST_COMMIT: state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      wcnt_q     <= '0;
      settle_q   <= '0;
      armed_q    <= 1'b0;
      cs_n_q     <= 1'b1;
      wr_n_q     <= 1'b1;
      pktend_n_q <= 1'b1;
    end else begin
      state_q    <= state_nx;
      wcnt_q     <= wcnt_nx;
      settle_q   <= settle_nx;
      armed_q    <= armed_nx;
      cs_n_q     <= (state_nx == ST_IDLE);
      wr_n_q     <= (state_nx != ST_STROBE);
      pktend_n_q <= (state_nx != ST_COMMIT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_q   <= '0;
      last_q <= 1'b0;
    end else if (take) begin
      fd_q   <= s_data;
      last_q <= s_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ep_q <= '0;
    else if (ep_load) ep_q <= EP_CODE;
  end

  assign ep_addr  = ep_q;
  assign cs_n     = cs_n_q;
  assign wr_n     = wr_n_q;
  assign oe_n     = 1'b1;
  assign pktend_n = pktend_n_q;
  assign fd       = fd_q;

  // R2
  ready_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> armed_q);
  // R3
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_q |-> !cs_n_q);
  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n_q) |=> !wr_n_q);
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_q && $past(!wr_n_q)) |-> $stable(fd_q));
  // R4
  data_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_q) |-> $stable(fd_q));
  // R6
  full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n_q) |-> !$past(full_sync));
  // R7
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_q) |-> ##1 wr_n_q ##1 wr_n_q);
  // R9
  pktend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pktend_n_q |-> (wr_n_q && !cs_n_q));
  // R9
  pktend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pktend_n_q |=> pktend_n_q);
endmodule

// File: rtl/usb_fifo_wr_master.sv
module usb_fifo_wr_master #(
  parameter int               DATA_W      = 16,
  parameter int               ADDR_W      = 2,
  parameter logic [ADDR_W-1:0] EP_CODE    = 2'b10,
  parameter int               WR_CYC      = 2,
  parameter int               SYNC_STAGES = 2,
  parameter int               PKT_WORDS   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic              usb_full,
  output logic [ADDR_W-1:0] ep_addr,
  output logic              cs_n,
  output logic              wr_n,
  output logic              oe_n,
  output logic              pktend_n,
  output logic [DATA_W-1:0] fd
);
  logic rst_q;
  logic full_sync;
  logic pkt_partial, word_done, pkt_clear;

  ufw_flag_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  ufw_flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_full_sync (
    .clk(clk), .rst_n(rst_q), .d(usb_full), .q(full_sync)
  );

  ufw_pkt_count #(.PKT_WORDS(PKT_WORDS)) u_pkt (
    .clk(clk), .rst_n(rst_q), .word_done(word_done),
    .clear(pkt_clear), .partial(pkt_partial)
  );

  ufw_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EP_CODE(EP_CODE),
    .WR_CYC(WR_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_q), .vsync(vsync),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .full_sync(full_sync), .pkt_partial(pkt_partial),
    .word_done(word_done), .pkt_clear(pkt_clear),
    .ep_addr(ep_addr), .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n),
    .pktend_n(pktend_n), .fd(fd)
  );

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !cs_n |-> oe_n);
endmodule

// File: tb/usb_fifo_wr_master_bench.sv
module usb_fifo_wr_master_bench;
  localparam int WR_CYC = 3;
  localparam int PKT_WORDS = 4;
  localparam logic [1:0] EP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0, s_valid = 1'b0, s_last = 1'b0, usb_full = 1'b0;
  logic [15:0] s_data = '0;
  logic s_ready, cs_n, wr_n, oe_n, pktend_n;
  logic [1:0] ep_addr;
  logic [15:0] fd;

  always #2.5 clk = ~clk;

  usb_fifo_wr_master #(.WR_CYC(WR_CYC), .PKT_WORDS(PKT_WORDS), .EP_CODE(EP)) u_usb_fifo_wr_master (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .usb_full(usb_full), .ep_addr(ep_addr),
    .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n), .pktend_n(pktend_n), .fd(fd)
  );

  int total = 0, bad = 0;
  int cyc = 0, low_run = 0, high_run = 0, rx_n = 0, pe_count = 0, last_rise = 0;
  bit wr_prev = 1'b1, pe_prev = 1'b1, had_strobe = 1'b0, gap_exact = 1'b1, done = 1'b0;
  logic [15:0] fd_first;
  logic [15:0] rx [0:63];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // strobe / packet-end monitor, sampled on falling edges
  always @(negedge clk) begin
    cyc++;
    if (!wr_n) begin
      if (wr_prev) begin
        fd_first = fd;
        low_run = 1;
        chk(cs_n == 1'b0, "R3 cs_n during strobe", cs_n, 0);
        chk(ep_addr == EP, "R3 ep_addr during strobe", ep_addr, EP);
        chk(oe_n == 1'b1, "R5 oe_n during strobe", oe_n, 1);
        if (had_strobe) begin
          if (gap_exact) chk(high_run == 4, "R7 strobe gap", high_run, 4);
          else chk(high_run >= 4, "R7 strobe gap min", high_run, 4);
        end
      end else begin
        low_run++;
        chk(fd == fd_first, "R4 fd stable while low", fd, fd_first);
      end
    end else begin
      if (!wr_prev) begin
        chk(low_run == WR_CYC, "R4 strobe width", low_run, WR_CYC);
        chk(fd == fd_first, "R4 fd held after rise", fd, fd_first);
        if (rx_n < 64) rx[rx_n] = fd;
        rx_n++;
        last_rise = cyc;
        high_run = 1;
        had_strobe = 1'b1;
      end else high_run++;
    end
    if (cs_n) had_strobe = 1'b0;
    wr_prev = wr_n;
    if (!pktend_n) begin
      if (pe_prev) begin
        pe_count++;
        chk(cyc - last_rise == 1, "R9 pktend delay", cyc - last_rise, 1);
        chk(cs_n == 1'b0, "R9 cs_n at pktend", cs_n, 0);
      end else chk(1'b0, "R9 pktend width", 2, 1);
    end
    pe_prev = pktend_n;
  end

  task automatic pulse_vsync();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
  endtask

  task automatic send(input logic [15:0] d, input bit last);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_last = last;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_frame(input int n, input logic [15:0] base, input bit bubbles);
    for (int i = 0; i < n; i++) begin
      send(base + 16'(i), i == n - 1);
      if (bubbles) begin
        @(negedge clk) s_valid = 1'b0;
        repeat (5) @(negedge clk);
      end
    end
    @(negedge clk) s_valid = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_rx(input int start, input int n, input logic [15:0] base, input string tag);
    chk(rx_n == start + n, {tag, " word count"}, rx_n, start + n);
    for (int i = 0; i < n; i++)
      chk(rx[start + i] == base + 16'(i), {tag, " word order"}, rx[start + i], base + 16'(i));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1, "R1 cs_n", cs_n, 1);
    chk(wr_n == 1, "R1 wr_n", wr_n, 1);
    chk(oe_n == 1, "R1 oe_n", oe_n, 1);
    chk(pktend_n == 1, "R1 pktend_n", pktend_n, 1);
    chk(ep_addr == 2'b00, "R1 ep_addr", ep_addr, 0);
    chk(s_ready == 0, "R1 s_ready", s_ready, 0);
  endtask

  task automatic t_gate();
    int r0 = rx_n;
    int seen = 0;
    @(negedge clk) s_valid = 1'b1; s_data = 16'hDEAD; s_last = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (s_ready || !wr_n) seen++;
    end
    chk(seen == 0, "R2 no accept before vsync", seen, 0);
    chk(rx_n == r0, "R2 no strobe before vsync", rx_n, r0);
    chk(cs_n == 1, "R2 stays idle before vsync", cs_n, 1);
    @(negedge clk) s_valid = 1'b0;
  endtask

  task automatic t_full_frame();
    int r0 = rx_n;
    int p0 = pe_count;
    gap_exact = 1'b1;
    pulse_vsync();
    send_frame(PKT_WORDS, 16'hA000, 1'b0);
    check_rx(r0, PKT_WORDS, 16'hA000, "R8 full frame");
    chk(pe_count == p0, "R10 no pktend on whole packet", pe_count, p0);
    chk(cs_n == 1, "R3 cs_n idle after frame", cs_n, 1);
    chk(ep_addr == EP, "R3 ep_addr kept", ep_addr, EP);
  endtask

  task automatic t_short_frame();
    int r0 = rx_n;
    int p0 = pe_count;
    pulse_vsync();
    send_frame(PKT_WORDS + 2, 16'hB100, 1'b0);
    check_rx(r0, PKT_WORDS + 2, 16'hB100, "R8 short frame");
    chk(pe_count == p0 + 1, "R9 one pktend on partial packet", pe_count, p0 + 1);
  endtask

  task automatic t_rearm();
    int r0 = rx_n;
    int seen = 0;
    @(negedge clk) s_valid = 1'b1; s_data = 16'hC000; s_last = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (s_ready) seen++;
    end
    chk(seen == 0, "R2 disarmed after frame end", seen, 0);
    chk(rx_n == r0, "R2 no strobe until rearm", rx_n, r0);
    pulse_vsync();
    send_frame(3, 16'hC000, 1'b0);
    check_rx(r0, 3, 16'hC000, "R2 rearmed frame");
  endtask

  task automatic t_full_wait();
    int r0 = rx_n;
    int p0 = pe_count;
    @(negedge clk) usb_full = 1'b1;
    pulse_vsync();
    @(negedge clk) s_valid = 1'b1; s_data = 16'hF00D; s_last = 1'b1;
    repeat (20) @(negedge clk);
    chk(rx_n == r0 && wr_n, "R6 no strobe while full", rx_n, r0);
    chk(cs_n == 0, "R3 cs_n low while waiting", cs_n, 0);
    usb_full = 1'b0;
    @(negedge clk);
    chk(wr_n == 1, "R6 held one edge after release", wr_n, 1);
    @(negedge clk);
    chk(wr_n == 1, "R6 held two edges after release", wr_n, 1);
    @(negedge clk);
    chk(wr_n == 0, "R6 strobe on third edge", wr_n, 0);
    chk(fd == 16'hF00D, "R8 word after full", fd, 16'hF00D);
    s_valid = 1'b0;
    repeat (12) @(negedge clk);
    check_rx(r0, 1, 16'hF00D, "R6 single word");
    chk(pe_count == p0 + 1, "R9 pktend on one-word frame", pe_count, p0 + 1);
  endtask

  task automatic t_bubbles();
    int r0 = rx_n;
    int p0 = pe_count;
    gap_exact = 1'b0;
    pulse_vsync();
    send_frame(2 * PKT_WORDS, 16'h5A00, 1'b1);
    check_rx(r0, 2 * PKT_WORDS, 16'h5A00, "R8 paused stream");
    chk(pe_count == p0, "R10 no pktend on two packets", pe_count, p0);
    gap_exact = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_gate();
    t_full_frame();
    t_short_frame();
    t_rearm();
    t_full_wait();
    t_bubbles();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule